// File: doc/BRIEF.md
# Sticky Limit-Violation Interrupt Status

This block keeps one status bit per monitored voltage or fan channel, up to sixteen channels packed into two byte-wide status registers. The conversion engine pulses a done strobe once per full round-robin pass. With that strobe it presents a vector of out-of-limit flags, one per channel. Each flagged channel sets its status bit. The bit then stays set, even if the channel comes back within limits, until software reads the register that holds it.

A per-channel mask selects which set bits may drive the shared, active-high interrupt request. Software reads the status bytes through a plain read port, which decodes a byte address. Each register answers at a primary address and at a mirror address, and both return the same data. Only a primary read clears the register, unless the `MIRROR_CLEARS` parameter makes mirror reads clear as well. The read port is a simple strobe with combinational data and has no back-pressure: a read completes in the cycle its strobe is high. The comparators and the converter sit outside this block.

Top module: `sticky_irq_status`

## Requirements
- R1: While reset is low, and right after reset is released, every status bit is 0 and `irq` is low.
- R2: Status bits change only on a cycle with `conv_done` high. Violation flags presented without `conv_done` have no effect.
- R3: On the clock edge that samples `conv_done` high, the status bit of every channel whose `viol` bit is 1 becomes 1. Channel i maps to bit i%8 of register i/8. Register 0 sits at primary address 0x43 and register 1 at 0x44.
- R4: `irq` is high exactly when at least one status bit is 1 and its `mask` bit is 0. It follows mask changes without waiting for a clock edge.
- R5: A read strobe at a primary address clears every bit of that register on the next edge. The other register is left untouched.
- R6: A bit stays set on later conversions whose flag is 0. A violation that persists after a read-clear sets the bit again, and `irq` rises again, at the next conversion.
- R7: When a set from `conv_done` and a read-clear of the same bit fall in the same cycle, the bit is 1 afterwards.
- R8: The mirror addresses 0x4C (register 0) and 0x4D (register 1) return the same data as the primary addresses. With the default `MIRROR_CLEARS` = 0, a read at a mirror address clears nothing.
- R9: `rd_data` is 0 for any address that is not a primary or mirror address. A read strobe at such an address changes no bit.
- R10: `rd_data` is combinational from `rd_addr` and shows the register contents as they were before the clearing edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe at the end of a conversion pass |
| viol | input | 16 | Out-of-limit flag per channel, valid with `conv_done` |
| mask | input | 16 | Interrupt mask per channel; 1 blocks that channel from `irq` |
| rd_en | input | 1 | Read strobe for the status port |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 8 | Status byte at `rd_addr` |
| irq | output | 1 | Active-high interrupt request |

## Verification
On every cycle the assertions check the following:
- no status bit rises without a conversion strobe;
- every flagged channel is set after a strobe, whether or not a read-clear falls in the same cycle;
- a primary read empties its register;
- mirror and unmapped reads leave the state alone;
- `irq` rises only after a conversion or a mask change.

The bench's ordered scenarios show the rest:
- the byte values returned at each address;
- bits that stay latched after the value has come back within limits;
- a new interrupt when a violation persists after a clear;
- the exact level of `irq` under masking;
- a reset arriving in the middle of a run.

// File: rtl/sis_pkg.sv
package sis_pkg;
  localparam int STAT_W = 8;

  function automatic int reg_count(input int num_ch);
    return (num_ch + STAT_W - 1) / STAT_W;
  endfunction
endpackage

// File: rtl/sis_rd_decode.sv
module sis_rd_decode #(
  parameter int NUM_REGS      = 2,
  parameter int ADDR_W        = 8,
  parameter int PRI_BASE      = 'h43,
  parameter int MIR_BASE      = 'h4C,
  parameter bit MIRROR_CLEARS = 1'b0
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NUM_REGS-1:0] sel,
  output logic [NUM_REGS-1:0] clr
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_dec
    localparam logic [ADDR_W-1:0] PA = ADDR_W'(PRI_BASE + r);
    localparam logic [ADDR_W-1:0] MA = ADDR_W'(MIR_BASE + r);
    logic hit_pri, hit_mir;
    assign hit_pri = (rd_addr == PA);
    assign hit_mir = (rd_addr == MA);
    assign sel[r]  = hit_pri | hit_mir;
    if (MIRROR_CLEARS) begin : g_mclr
      assign clr[r] = rd_en & (hit_pri | hit_mir);
    end else begin : g_pclr
      assign clr[r] = rd_en & hit_pri;
    end
  end
endmodule

// File: rtl/sis_stat_reg.sv
module sis_stat_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic [W-1:0] set_bits,
  input  logic         clr_en,
  output logic [W-1:0] q
);
  logic [W-1:0] kept, fresh;

  always_comb begin
    kept  = clr_en ? '0 : q;
    fresh = set_en ? set_bits : '0;
  end

  // set has priority over clear: fresh is ORed after the clear is applied
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= kept | fresh;
  end
endmodule

// File: rtl/sis_irq_merge.sv
module sis_irq_merge #(
  parameter int NUM_CH = 16
) (
  input  logic [NUM_CH-1:0] stat,
  input  logic [NUM_CH-1:0] mask,
  output logic              irq
);
  logic [NUM_CH-1:0] live;
  assign live = stat & ~mask;
  assign irq  = |live;
endmodule

// File: rtl/sticky_irq_status.sv
module sticky_irq_status #(
  parameter int NUM_CH        = 16,
  parameter int ADDR_W        = 8,
  parameter int PRI_BASE      = 'h43,
  parameter int MIR_BASE      = 'h4C,
  parameter bit MIRROR_CLEARS = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [NUM_CH-1:0] viol,
  input  logic [NUM_CH-1:0] mask,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              irq
);
  import sis_pkg::*;
  localparam int NUM_REGS = reg_count(NUM_CH);
  localparam int PAD_W    = NUM_REGS * STAT_W;

  logic [NUM_REGS-1:0]   sel, clr;
  logic [PAD_W-1:0]      viol_pad;
  logic [PAD_W-1:0]      stat_pad;
  logic [NUM_CH-1:0]     stat_q;

  assign viol_pad = PAD_W'(viol);

  sis_rd_decode #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .PRI_BASE(PRI_BASE),
    .MIR_BASE(MIR_BASE), .MIRROR_CLEARS(MIRROR_CLEARS)
  ) u_dec (
    .rd_en(rd_en), .rd_addr(rd_addr), .sel(sel), .clr(clr)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    sis_stat_reg #(.W(STAT_W)) u_reg (
      .clk(clk), .rst_n(rst_n),
      .set_en(conv_done),
      .set_bits(viol_pad[r*STAT_W +: STAT_W]),
      .clr_en(clr[r]),
      .q(stat_pad[r*STAT_W +: STAT_W])
    );
  end

  assign stat_q = stat_pad[NUM_CH-1:0];

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (sel[r]) rd_data = rd_data | stat_pad[r*STAT_W +: STAT_W];
    end
  end

  sis_irq_merge #(.NUM_CH(NUM_CH)) u_irq (
    .stat(stat_q), .mask(mask), .irq(irq)
  );
endmodule

// File: rtl/sticky_irq_status_chk.sv
module sticky_irq_status_chk #(
  parameter int NUM_CH        = 16,
  parameter int ADDR_W        = 8,
  parameter int PRI_BASE      = 'h43,
  parameter int MIR_BASE      = 'h4C,
  parameter bit MIRROR_CLEARS = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_done,
  input logic [NUM_CH-1:0] viol,
  input logic [NUM_CH-1:0] mask,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              irq,
  input logic [NUM_CH-1:0] stat_q
);
  localparam int NR = (NUM_CH + 7) / 8;

  logic mapped;
  assign mapped = (int'(rd_addr) >= PRI_BASE && int'(rd_addr) < PRI_BASE + NR) ||
                  (int'(rd_addr) >= MIR_BASE && int'(rd_addr) < MIR_BASE + NR);

  // R2: nothing rises without a conversion strobe
  a_r2_no_set_without_done: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> ((stat_q & ~$past(stat_q)) == '0));

  // R3 and R7: every flagged channel is set, even against a same-cycle clear
  a_r3_flag_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> ((stat_q & $past(viol)) == $past(viol)));

  // R4: irq rises only after a conversion or a mask change
  a_r4_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(conv_done) || (mask != $past(mask))));

  // R9: unmapped reads leave the state unchanged
  a_r9_unmapped_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped && !conv_done) |=> $stable(stat_q));

  for (genvar r = 0; r < NR; r++) begin : g_chk
    localparam int LO = r * 8;
    localparam int HI = (LO + 8 > NUM_CH) ? NUM_CH - 1 : LO + 7;
    // R5: primary read empties its register
    a_r5_primary_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && int'(rd_addr) == PRI_BASE + r && !conv_done) |=> (stat_q[HI:LO] == '0));
    if (!MIRROR_CLEARS) begin : g_mir
      // R8: mirror reads leave the state unchanged
      a_r8_mirror_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && int'(rd_addr) == MIR_BASE + r && !conv_done) |=> $stable(stat_q));
    end
  end
endmodule

bind sticky_irq_status sticky_irq_status_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .PRI_BASE(PRI_BASE),
  .MIR_BASE(MIR_BASE), .MIRROR_CLEARS(MIRROR_CLEARS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .viol(viol), .mask(mask),
  .rd_en(rd_en), .rd_addr(rd_addr), .irq(irq), .stat_q(stat_q)
);

// File: tb/test_sticky_irq_status.sv
module test_sticky_irq_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_done = 1'b0;
  logic [15:0] viol = '0;
  logic [15:0] mask = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sticky_irq_status i_sticky_irq_status (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .viol(viol), .mask(mask),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // {done, viol, mask, rd, addr, exp_data (before edge), exp_irq (after edge)}
  localparam int NV = 17;
  localparam logic [NV-1:0][50:0] TBL = {
    {1'b0,16'h0000,16'h0000,1'b1,8'h50,8'h00,1'b1}, // 16 R9 unmapped read
    {1'b1,16'h0010,16'h0000,1'b0,8'h43,8'h00,1'b1}, // 15 R6 persisting re-sets
    {1'b0,16'h0000,16'h0000,1'b1,8'h43,8'h10,1'b0}, // 14 R5
    {1'b1,16'h0010,16'h0000,1'b0,8'h43,8'h00,1'b1}, // 13 R3
    {1'b0,16'h0000,16'h0000,1'b1,8'h44,8'h80,1'b0}, // 12 R5
    {1'b0,16'h0000,16'h0000,1'b1,8'h43,8'h01,1'b1}, // 11 R5 other reg kept
    {1'b1,16'h8001,16'h0000,1'b0,8'h43,8'h00,1'b1}, // 10 R3 both regs
    {1'b0,16'hFFFF,16'h0000,1'b0,8'h43,8'h00,1'b0}, // 9  R2 no strobe
    {1'b0,16'h0000,16'h0000,1'b1,8'h44,8'h01,1'b0}, // 8  R5
    {1'b1,16'h0000,16'h0000,1'b0,8'h4D,8'h01,1'b1}, // 7  R6 sticky
    {1'b1,16'h0100,16'h0000,1'b1,8'h44,8'h01,1'b1}, // 6  R7 set wins
    {1'b0,16'h0000,16'h0000,1'b0,8'h44,8'h01,1'b1}, // 5  R4 unmask
    {1'b1,16'h0100,16'h0100,1'b0,8'h44,8'h00,1'b0}, // 4  R4 masked
    {1'b0,16'h0000,16'h0000,1'b1,8'h43,8'h03,1'b0}, // 3  R5 clear
    {1'b0,16'h0000,16'h0000,1'b1,8'h4C,8'h03,1'b1}, // 2  R8 mirror read
    {1'b0,16'h0000,16'h0000,1'b0,8'h4C,8'h03,1'b1}, // 1  R10 peek
    {1'b1,16'h0003,16'h0000,1'b0,8'h00,8'h00,1'b1}  // 0  R3
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq in reset", {15'd0, irq}, 16'd0);
    rd_addr = 8'h43; #1;
    check("R1 reg0 in reset", {8'd0, rd_data}, 16'd0);
    rd_addr = 8'h44; #1;
    check("R1 reg1 in reset", {8'd0, rd_data}, 16'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 irq after reset", {15'd0, irq}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      logic [50:0] v;
      v = TBL[i];
      conv_done = v[50];
      viol      = v[49:34];
      mask      = v[33:18];
      rd_en     = v[17];
      rd_addr   = v[16:9];
      #1;
      check($sformatf("R10/R8 rd_data step %0d", i), {8'd0, rd_data}, {8'd0, v[8:1]});
      @(posedge clk); #1;
      check($sformatf("R4 irq step %0d", i), {15'd0, irq}, {15'd0, v[0]});
    end

    // R4: masking a live bit drops irq without a clock edge
    conv_done = 1'b0; rd_en = 1'b0; mask = 16'h0010; #1;
    check("R4 mask drops irq", {15'd0, irq}, 16'd0);
    mask = 16'h0000; #1;
    check("R4 unmask restores irq", {15'd0, irq}, 16'd1);

    // R1: reset in the middle of a run clears everything
    rst_n = 1'b0; #1;
    check("R1 mid-run reset irq", {15'd0, irq}, 16'd0);
    rd_addr = 8'h43; #1;
    check("R1 mid-run reset data", {8'd0, rd_data}, 16'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 state after re-release", {15'd0, irq}, 16'd0);

    finish_run();
  end
endmodule